// File: doc/BRIEF.md
# Receive Loss-of-Signal Monitor with Data Muting

This block watches one E1 receive channel for loss of signal. An analog slicer outside the block supplies two amplitude flags. One reports that the line level has dropped below the declare threshold, 20 dB or more under nominal. The other reports that the level is back within 15 dB of nominal. The 5 dB gap between the two thresholds gives hysteresis. The block also receives the recovered positive and negative mark pulses and a tick that marks each bit period (unit interval, UI).

The block is a two-state machine. In state `ST_LIVE` the line is good and `los` is low. Transition `DECLARE` moves to `ST_LOST` once the low-amplitude flag has held for a programmed number of ticks without a break. In state `ST_LOST`, `los` is high. Transition `RESTORE` moves back to `ST_LIVE` once the clear flag has held for a second programmed number of ticks without a break. Each delay is an 8-bit setting, and any value below 10 is raised to 10, so both delays stay within 10 to 255 UI. While `los` is high, both receive data outputs are forced to zero so that a dead line cannot make them chatter. No recovered clock is passed on.

Top module: `rx_los_guard`

## Requirements
- R1: After reset, `los` is 1 and both `rx_pos` and `rx_neg` are 0, whatever the mark inputs are.
- R2: In `ST_LIVE`, if `amp_low` is held at 1, `los` rises right after the N-th `bit_tick` edge, where N is the effective declare delay. After N-1 ticks it is still 0.
- R3: In `ST_LOST`, if `amp_ok` is held at 1 and `amp_low` at 0, `los` falls right after the N-th `bit_tick` edge, where N is the effective clear delay. After N-1 ticks it is still 1.
- R4: Any cycle in which the active condition is false sets its count back to zero. A fresh full delay is then needed.
- R5: While both amplitude flags are 0, the amplitude is between the thresholds. The current `los` level holds for any length of time, and both counts return to zero.
- R6: A delay setting below 10 acts as 10. Settings from 10 to 255 are used unchanged.
- R7: Only cycles with `bit_tick` = 1 advance a count. `los` changes only on an edge where `bit_tick` is 1.
- R8: While `los` is 1, `rx_pos` and `rx_neg` are 0 in every cycle.
- R9: While `los` is 0, `rx_pos` equals `mark_pos` and `rx_neg` equals `mark_neg` in the same cycle.
- R10: If both amplitude flags are 1 at once, `amp_low` wins. That state counts toward declaring and never toward clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| amp_low | input | 1 | Amplitude below declare threshold |
| amp_ok | input | 1 | Amplitude at or above clear threshold |
| mark_pos | input | 1 | Recovered positive mark pulse |
| mark_neg | input | 1 | Recovered negative mark pulse |
| declare_dly | input | 8 | Declare delay in UI (minimum 10 applied) |
| clear_dly | input | 8 | Clear delay in UI (minimum 10 applied) |
| los | output | 1 | Loss of signal, active high |
| rx_pos | output | 1 | Muted positive receive data |
| rx_neg | output | 1 | Muted negative receive data |

## Verification
A wrong state register shows up at once on `los` and on the mute gating. The data outputs then pass or block marks in the very cycle a mark arrives. A count that advances without a tick, misses a reset on a broken condition, or skips the minimum clamp moves the `los` edge away from the exact tick where it belongs. The bench therefore samples `los` one tick before and right after the expected transition edge. A count that is not cleared between thresholds appears as an early transition on the next attempt, once fewer than the full number of ticks has passed.

// File: rtl/rx_los_pkg.sv
package rx_los_pkg;
    localparam int DLY_W     = 8;
    localparam int MIN_DELAY = 10;

    typedef enum logic {
        ST_LIVE = 1'b0,
        ST_LOST = 1'b1
    } los_state_e;
endpackage

// File: rtl/los_delay_clamp.sv
module los_delay_clamp #(
    parameter int W   = 8,
    parameter int MIN = 10
) (
    input  logic [W-1:0] raw_dly,
    output logic [W-1:0] eff_dly
);
    localparam logic [W-1:0] MIN_V = W'(MIN);

    always_comb begin
        eff_dly = (raw_dly < MIN_V) ? MIN_V : raw_dly;
    end

    // R6
    always_comb begin
        clamp_floor_chk: assert (eff_dly >= MIN_V);
    end
endmodule

// File: rtl/los_dwell_counter.sv
module los_dwell_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         cond,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;
    logic [W:0]   next_cnt;

    assign next_cnt = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
    assign done     = enable && cond && tick && (next_cnt >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enable || !cond || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= next_cnt[W-1:0];
        end
    end

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !$stable(cnt)) |-> $past(tick));

    // R4
    cnt_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond) |=> (cnt == '0));
endmodule

// File: rtl/rx_los_guard.sv
module rx_los_guard
    import rx_los_pkg::*;
#(
    parameter int W   = DLY_W,
    parameter int MIN = MIN_DELAY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_tick,
    input  logic         amp_low,
    input  logic         amp_ok,
    input  logic         mark_pos,
    input  logic         mark_neg,
    input  logic [W-1:0] declare_dly,
    input  logic [W-1:0] clear_dly,
    output logic         los,
    output logic         rx_pos,
    output logic         rx_neg
);
    los_state_e   state_q, state_d;
    logic [W-1:0] decl_lim, clr_lim;
    logic         decl_done, clr_done;
    logic         clr_cond;

    assign clr_cond = amp_ok && !amp_low;

    los_delay_clamp #(.W(W), .MIN(MIN)) u_decl_clamp (
        .raw_dly (declare_dly),
        .eff_dly (decl_lim)
    );

    los_delay_clamp #(.W(W), .MIN(MIN)) u_clr_clamp (
        .raw_dly (clear_dly),
        .eff_dly (clr_lim)
    );

    los_dwell_counter #(.W(W)) u_decl_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (state_q == ST_LIVE),
        .cond   (amp_low),
        .tick   (bit_tick),
        .limit  (decl_lim),
        .done   (decl_done)
    );

    los_dwell_counter #(.W(W)) u_clr_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (state_q == ST_LOST),
        .cond   (clr_cond),
        .tick   (bit_tick),
        .limit  (clr_lim),
        .done   (clr_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LIVE: if (decl_done) state_d = ST_LOST;
            ST_LOST: if (clr_done)  state_d = ST_LIVE;
            default: state_d = ST_LOST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOST;
        else        state_q <= state_d;
    end

    always_comb begin
        los    = 1'b1;
        rx_pos = 1'b0;
        rx_neg = 1'b0;
        unique case (state_q)
            ST_LIVE: begin
                los    = 1'b0;
                rx_pos = mark_pos;
                rx_neg = mark_neg;
            end
            ST_LOST: begin
                los    = 1'b1;
            end
            default: los = 1'b1;
        endcase
    end

    // R2
    declare_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> $past(amp_low));

    // R3
    restore_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los) |-> ($past(amp_ok) && !$past(amp_low)));

    // R7
    tick_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(los) |-> $past(bit_tick));

    // R8
    mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        los |-> (!rx_pos && !rx_neg));
endmodule

// File: tb/rx_los_guard_test.sv
module rx_los_guard_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_tick, amp_low, amp_ok, mark_pos, mark_neg;
    logic [7:0] declare_dly, clear_dly;
    logic       los, rx_pos, rx_neg;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    rx_los_guard uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .amp_low(amp_low), .amp_ok(amp_ok),
        .mark_pos(mark_pos), .mark_neg(mark_neg),
        .declare_dly(declare_dly), .clear_dly(clear_dly),
        .los(los), .rx_pos(rx_pos), .rx_neg(rx_neg)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic steps(input int n, input logic tk);
        for (int i = 0; i < n; i++) begin
            bit_tick = tk;
            @(negedge clk);
        end
        bit_tick = 1'b0;
    endtask

    task automatic set_amp(input logic lo, input logic ok);
        amp_low = lo;
        amp_ok  = ok;
    endtask

    task automatic t_reset();
        mark_pos = 1'b1; mark_neg = 1'b1;
        #1;
        chk("R1 los after reset", los, 1'b1);
        chk("R1 rx_pos muted", rx_pos, 1'b0);
        chk("R1 rx_neg muted", rx_neg, 1'b0);
        mark_pos = 1'b0; mark_neg = 1'b0;
    endtask

    task automatic t_clear_basic();
        clear_dly = 8'd12;
        set_amp(1'b0, 1'b1);
        steps(11, 1'b1);
        chk("R3 los held at N-1", los, 1'b1);
        steps(1, 1'b1);
        chk("R3 los cleared at N", los, 1'b0);
        mark_pos = 1'b1; #1;
        chk("R9 rx_pos follows", rx_pos, 1'b1);
        chk("R9 rx_neg idle", rx_neg, 1'b0);
        mark_pos = 1'b0; mark_neg = 1'b1; #1;
        chk("R9 rx_neg follows", rx_neg, 1'b1);
        mark_neg = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_declare_basic();
        declare_dly = 8'd20;
        set_amp(1'b1, 1'b0);
        steps(19, 1'b1);
        chk("R2 los low at N-1", los, 1'b0);
        steps(1, 1'b1);
        chk("R2 los set at N", los, 1'b1);
        mark_pos = 1'b1; mark_neg = 1'b1; #1;
        chk("R8 rx_pos muted", rx_pos, 1'b0);
        chk("R8 rx_neg muted", rx_neg, 1'b0);
        mark_pos = 1'b0; mark_neg = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_clamp();
        clear_dly = 8'd0;
        set_amp(1'b0, 1'b1);
        steps(9, 1'b1);
        chk("R6 clear floor at 9", los, 1'b1);
        steps(1, 1'b1);
        chk("R6 clear floor at 10", los, 1'b0);
        declare_dly = 8'd3;
        set_amp(1'b1, 1'b0);
        steps(9, 1'b1);
        chk("R6 declare floor at 9", los, 1'b0);
        steps(1, 1'b1);
        chk("R6 declare floor at 10", los, 1'b1);
    endtask

    task automatic t_restart();
        clear_dly = 8'd12;
        set_amp(1'b0, 1'b1);
        steps(8, 1'b1);
        set_amp(1'b0, 1'b0);
        steps(1, 1'b1);
        chk("R5 los held between thresholds", los, 1'b1);
        set_amp(1'b0, 1'b1);
        steps(11, 1'b1);
        chk("R4 count restarted", los, 1'b1);
        steps(1, 1'b1);
        chk("R4 cleared after full delay", los, 1'b0);
    endtask

    task automatic t_middle_hold();
        set_amp(1'b0, 1'b0);
        steps(300, 1'b1);
        chk("R5 live held between thresholds", los, 1'b0);
        declare_dly = 8'd15;
        set_amp(1'b1, 1'b0);
        steps(10, 1'b1);
        set_amp(1'b0, 1'b0);
        steps(5, 1'b1);
        set_amp(1'b1, 1'b0);
        steps(14, 1'b1);
        chk("R5 declare count reset in middle", los, 1'b0);
        set_amp(1'b0, 1'b1);
        @(negedge clk);
    endtask

    task automatic t_max();
        declare_dly = 8'd255;
        set_amp(1'b1, 1'b0);
        steps(254, 1'b1);
        chk("R2 max delay at 254", los, 1'b0);
        steps(1, 1'b1);
        chk("R2 max delay at 255", los, 1'b1);
    endtask

    task automatic t_both_flags();
        clear_dly = 8'd10;
        set_amp(1'b1, 1'b1);
        steps(300, 1'b1);
        chk("R10 amp_low wins in lost", los, 1'b1);
    endtask

    task automatic t_sparse();
        clear_dly = 8'd10;
        set_amp(1'b0, 1'b1);
        steps(50, 1'b0);
        chk("R7 no tick no count", los, 1'b1);
        for (int k = 0; k < 9; k++) begin
            steps(1, 1'b1);
            steps(3, 1'b0);
        end
        chk("R7 sparse at 9 ticks", los, 1'b1);
        steps(1, 1'b1);
        chk("R7 sparse at 10 ticks", los, 1'b0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0; bit_tick = 1'b0; amp_low = 1'b0; amp_ok = 1'b1;
        mark_pos = 1'b0; mark_neg = 1'b0;
        declare_dly = 8'd10; clear_dly = 8'd10;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_clear_basic();
        t_declare_basic();
        t_clamp();
        t_restart();
        t_middle_hold();
        t_max();
        t_both_flags();
        t_sparse();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule